// File: doc/BRIEF.md
# Multiplexed GPIO Port with Edge Interrupts

This block is one general-purpose I/O port of a small microcontroller, eight pins wide by default. Each pin is driven either by a software-written output bit or by the output of an attached peripheral, chosen by a per-pin select bit. Two per-pin overrides come before that choice. An analog-input enable turns the digital driver off and blanks the digital input. An LCD-segment enable hands the pad to the segment driver.

The pad input passes through a two-flop synchroniser. The synchronised value feeds the input register, the peripheral input bus and an edge detector. Each pin has an edge-select bit, a sticky interrupt flag and an enable bit. The port interrupt line is the OR of all the enabled flags. Software reaches the seven byte-wide registers through a simple single-cycle write port and a combinational read port. A parameter removes the interrupt registers for ports that have no interrupt logic.

Top module: `gpio_mux_port`

## Requirements
- R1: With neither override active on a pin, `pad_oe` follows that pin's direction bit: 0 means input (driver off) and 1 means output.
- R2: With neither override active, a select bit of 0 drives `pad_out` from the output register bit, and a select bit of 1 drives it from `periph_out`.
- R3: While `analog_en` is 1 on a pin, that pin has `pad_oe`=0 and `pad_out`=0, its input-register bit and `periph_in` bit read 0, and no edge on it sets its flag. This override ranks above the segment override.
- R4: While `seg_en` is 1 and `analog_en` is 0 on a pin, `pad_oe`=1 and `pad_out` equals `seg_val` for that pin, whatever its direction and select bits are.
- R5: The input register (address 0) and `periph_in` show the pad value two clock edges after it changes, for every direction and select setting.
- R6: An edge-select bit of 0 flags a rising edge and 1 flags a falling edge. The flag reads 1 after the third clock edge following the pad change.
- R7: Changing an edge-select bit while the pad is steady sets no flag.
- R8: Writing the flag register (address 6) loads every flag with the written byte. If a hardware edge arrives in the same cycle as a write of 0 to that bit, the flag ends up as 1. Flags never clear without a write.
- R9: `irq` is 1 exactly when some pin has both its flag and its enable bit (address 4) set.
- R10: After reset, the output, direction, select, enable, edge-select and flag registers read 0, `pad_oe` is 0 and `irq` is 0.
- R11: The address map is: input 0 (read-only, writes ignored), output 1, direction 2, select 3, enable 4, edge-select 5, flag 6. Address 7 reads 0. Writable registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` (combinational) |
| pad_in | input | W | Raw pad input values |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output-driver enables |
| periph_out | input | W | Peripheral output per pin |
| periph_in | output | W | Synchronised pad input to peripherals |
| analog_en | input | W | Per-pin analog-input override |
| seg_en | input | W | Per-pin LCD-segment override |
| seg_val | input | W | Segment drive value per pin |
| irq | output | 1 | Port interrupt request |

## Verification
The pad multiplexer is purely combinational, so the bench checks `pad_out` and `pad_oe` 1 ns after it changes an input. A register write takes effect on the edge where `wr_en` is sampled. The input register and `periph_in` update on the second rising edge after a pad change, and a flag (together with `irq`) is set on the third. The edge tests therefore drive the pad on a falling edge and count the rising edges one at a time. At 1 ns after the second edge they check that the input already reads the new value and that the flag is still clear, and at 1 ns after the third edge they check that the flag is set. The same-cycle collision test places the clearing write on exactly that third edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN  = 3'd0,
    REG_OUT = 3'd1,
    REG_DIR = 3'd2,
    REG_SEL = 3'd3,
    REG_IE  = 3'd4,
    REG_IES = 3'd5,
    REG_IFG = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] out_reg,
  input  logic [W-1:0] dir_reg,
  input  logic [W-1:0] sel_reg,
  input  logic [W-1:0] periph_out,
  input  logic [W-1:0] analog_en,
  input  logic [W-1:0] seg_en,
  input  logic [W-1:0] seg_val,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] dig_in
);
  // Per pin: analog override, then segment override, then port/peripheral.
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic dig_val;
    assign dig_val    = sel_reg[i] ? periph_out[i] : out_reg[i];
    assign pad_oe[i]  = analog_en[i] ? 1'b0 : (seg_en[i] ? 1'b1 : dir_reg[i]);
    assign pad_out[i] = analog_en[i] ? 1'b0 : (seg_en[i] ? seg_val[i] : dig_val);
    assign dig_in[i]  = sync_in[i] & ~analog_en[i];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W       = 8,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] analog_en,
  input  logic         wr_ie,
  input  logic         wr_ies,
  input  logic         wr_ifg,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ie_q,
  output logic [W-1:0] ies_q,
  output logic [W-1:0] ifg_q,
  output logic         irq
);
  if (HAS_IRQ) begin : g_irq
    logic [W-1:0] prev_q;
    logic [W-1:0] ie_d, ies_d, ifg_d;
    logic [W-1:0] rise, fall, edge_hit;

    assign rise     = sync_in & ~prev_q;
    assign fall     = ~sync_in & prev_q;
    assign edge_hit = ((rise & ~ies_q) | (fall & ies_q)) & ~analog_en;

    always_comb begin
      ie_d  = wr_ie  ? wdata : ie_q;
      ies_d = wr_ies ? wdata : ies_q;
      ifg_d = (wr_ifg ? wdata : ifg_q) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        ie_q   <= '0;
        ies_q  <= '0;
        ifg_q  <= '0;
      end else begin
        prev_q <= sync_in;
        ie_q   <= ie_d;
        ies_q  <= ies_d;
        ifg_q  <= ifg_d;
      end
    end

    assign irq = |(ifg_q & ie_q);
  end else begin : g_no_irq
    assign ie_q  = '0;
    assign ies_q = '0;
    assign ifg_q = '0;
    assign irq   = 1'b0;
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_IRQ     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic [W-1:0]      periph_out,
  output logic [W-1:0]      periph_in,
  input  logic [W-1:0]      analog_en,
  input  logic [W-1:0]      seg_en,
  input  logic [W-1:0]      seg_val,
  output logic              irq
);
  logic [W-1:0] out_q, dir_q, sel_q;
  logic [W-1:0] out_d, dir_d, sel_d;
  logic [W-1:0] ie_q, ies_q, ifg_q;
  logic [W-1:0] sync_in, dig_in;
  logic         wr_out, wr_dir, wr_sel, wr_ie, wr_ies, wr_ifg;

  assign wr_out = wr_en && (addr == REG_OUT);
  assign wr_dir = wr_en && (addr == REG_DIR);
  assign wr_sel = wr_en && (addr == REG_SEL);
  assign wr_ie  = wr_en && (addr == REG_IE);
  assign wr_ies = wr_en && (addr == REG_IES);
  assign wr_ifg = wr_en && (addr == REG_IFG);

  always_comb begin
    out_d = wr_out ? wdata : out_q;
    dir_d = wr_dir ? wdata : dir_q;
    sel_d = wr_sel ? wdata : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      sel_q <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
      sel_q <= sel_d;
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_sync(sync_in)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .out_reg(out_q), .dir_reg(dir_q), .sel_reg(sel_q),
    .periph_out(periph_out), .analog_en(analog_en),
    .seg_en(seg_en), .seg_val(seg_val), .sync_in(sync_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .dig_in(dig_in)
  );

  gpio_irq_bank #(.W(W), .HAS_IRQ(HAS_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .analog_en(analog_en),
    .wr_ie(wr_ie), .wr_ies(wr_ies), .wr_ifg(wr_ifg), .wdata(wdata),
    .ie_q(ie_q), .ies_q(ies_q), .ifg_q(ifg_q), .irq(irq)
  );

  assign periph_in = dig_in;

  always_comb begin
    unique case (addr)
      REG_IN:  rdata = dig_in;
      REG_OUT: rdata = out_q;
      REG_DIR: rdata = dir_q;
      REG_SEL: rdata = sel_q;
      REG_IE:  rdata = ie_q;
      REG_IES: rdata = ies_q;
      REG_IFG: rdata = ifg_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] periph_in,
  input logic [W-1:0] analog_en,
  input logic [W-1:0] seg_en,
  input logic [W-1:0] seg_val,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] ifg_q
);
  logic         flag_wr;
  logic [W-1:0] plain;
  logic [W-1:0] seg_only;
  assign flag_wr  = wr_en && (addr == 3'd6);
  assign plain    = ~analog_en & ~seg_en;
  assign seg_only = seg_en & ~analog_en;

  // R1
  a_r1_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & plain) == (dir_q & plain));

  // R3
  a_r3_analog_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | periph_in) & analog_en) == '0);

  // R4
  a_r4_segment_owns_pad: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & seg_only) == seg_only) && ((pad_out & seg_only) == (seg_val & seg_only)));

  // R8
  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((ifg_q & $past(ifg_q)) == $past(ifg_q)));

  // R3
  a_r3_analog_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((ifg_q & ~$past(ifg_q) & $past(analog_en)) == '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .pad_out(pad_out), .pad_oe(pad_oe), .periph_in(periph_in),
  .analog_en(analog_en), .seg_en(seg_en), .seg_val(seg_val),
  .dir_q(dir_q), .ifg_q(ifg_q)
);

// File: tb/gpio_mux_port_tb_top.sv
module gpio_mux_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   addr;
  logic [W-1:0] wdata, rdata, pad_in, pad_out, pad_oe;
  logic [W-1:0] periph_out, periph_in, analog_en, seg_en, seg_val;
  logic         irq;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done  = 1'b0;

  always #4 clk = ~clk;

  gpio_mux_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_out(periph_out), .periph_in(periph_in), .analog_en(analog_en),
    .seg_en(seg_en), .seg_val(seg_val), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R10 pad_oe", pad_oe, 0);
    chk("R10 irq", irq, 0);
    for (int a = 1; a < 7; a++) begin
      rd(a[2:0], v);
      chk("R10 reg zero", v, 0);
    end
  endtask

  task automatic t_dir_sel();
    wr(3'd2, 8'hA5);
    #1 chk("R1 oe follows dir", pad_oe, 8'hA5);
    wr(3'd1, 8'h3C);
    wr(3'd3, 8'h0F);
    periph_out = 8'h05;
    #1 chk("R2 out/periph mux", pad_out, 8'h35);
    periph_out = 8'h0A;
    #1 chk("R2 periph change", pad_out, 8'h3A);
  endtask

  task automatic t_regmap();
    logic [W-1:0] v;
    wr(3'd4, 8'h00); wr(3'd5, 8'h96);
    rd(3'd1, v); chk("R11 out readback", v, 8'h3C);
    rd(3'd2, v); chk("R11 dir readback", v, 8'hA5);
    rd(3'd3, v); chk("R11 sel readback", v, 8'h0F);
    rd(3'd5, v); chk("R11 ies readback", v, 8'h96);
    rd(3'd7, v); chk("R11 unused addr", v, 8'h00);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_input_sync();
    logic [W-1:0] v;
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk);
    pad_in = 8'h5A; addr = 3'd0;
    @(posedge clk); #1 chk("R5 one edge old", rdata, 8'h00);
    @(posedge clk); #1 chk("R5 input two edges", rdata, 8'h5A);
    chk("R5 periph_in", periph_in, 8'h5A);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R11 input write ignored", v, 8'h5A);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    rd(3'd0, v); chk("R5 input other dir/sel", v, 8'h5A);
  endtask

  task automatic t_edges();
    wr(3'd6, 8'h00);
    wr(3'd5, 8'h08);
    @(negedge clk);
    pad_in = 8'h56;        // bit2 rises, bit3 falls
    addr = 3'd0;
    @(posedge clk); @(posedge clk);
    #1 chk("R6 input seen", rdata, 8'h56);
    addr = 3'd6;
    #1 chk("R6 flag not yet", rdata, 8'h00);
    @(posedge clk);
    #1 chk("R6 rise+fall flags", rdata, 8'h0C);
    settle(2);
    @(negedge clk);
    pad_in = 8'h52;        // bit2 falls, not selected
    settle(4);
    #1 chk("R6 wrong edge ignored", rdata, 8'h0C);
  endtask

  task automatic t_irq();
    wr(3'd4, 8'h04);
    #1 chk("R9 irq enabled flag", irq, 1);
    wr(3'd4, 8'h10);
    #1 chk("R9 irq masked", irq, 0);
    wr(3'd6, 8'h10);
    #1 chk("R9 sw-set flag irq", irq, 1);
    wr(3'd6, 8'h00);
    #1 chk("R8 sw clear", irq, 0);
    addr = 3'd6;
    #1 chk("R8 flags cleared", rdata, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_ies_change();
    wr(3'd6, 8'h00);
    wr(3'd5, 8'hFF);
    settle(3);
    wr(3'd5, 8'h00);
    settle(3);
    addr = 3'd6;
    #1 chk("R7 ies toggle no flag", rdata, 8'h00);
  endtask

  task automatic t_collision();
    wr(3'd6, 8'h00);
    @(negedge clk);
    pad_in = 8'hD2;        // bit7 rises
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd6; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R8 edge beats clear", rdata, 8'h80);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_analog();
    logic [W-1:0] v;
    wr(3'd2, 8'hFF); wr(3'd1, 8'hFF); wr(3'd3, 8'h00);
    analog_en = 8'h01; seg_en = 8'h01; seg_val = 8'hFF;
    #1 chk("R3 oe off", pad_oe[0], 0);
    chk("R3 out low", pad_out[0], 0);
    @(negedge clk);
    pad_in = 8'hD3;        // bit0 rises under analog
    settle(4);
    rd(3'd0, v); chk("R3 input reads 0", v[0], 0);
    chk("R3 periph_in 0", periph_in[0], 0);
    rd(3'd6, v); chk("R3 no flag", v, 8'h00);
    analog_en = 8'h00;
    settle(3);
    rd(3'd6, v); chk("R3 release no flag", v, 8'h00);
    seg_en = 8'h00;
  endtask

  task automatic t_segment();
    wr(3'd2, 8'h00); wr(3'd3, 8'hFF);
    periph_out = 8'h00;
    seg_en = 8'h10; seg_val = 8'h10;
    #1 chk("R4 seg oe", pad_oe, 8'h10);
    chk("R4 seg value 1", pad_out, 8'h10);
    seg_val = 8'h00;
    #1 chk("R4 seg value 0", pad_out, 8'h00);
    seg_en = 8'h00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pad_in = '0;
    periph_out = '0; analog_en = '0; seg_en = '0; seg_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_dir_sel();
    t_regmap();
    t_input_sync();
    t_edges();
    t_irq();
    t_ies_change();
    t_collision();
    t_analog();
    t_segment();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule